// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit microcontroller core. It is purely combinational. In one evaluation it takes two byte operands, the carry and zero flags as they stand before the operation, and an operation code. The second operand is either a register value or an immediate; the selection is made upstream.

It returns three things:
- the byte result;
- a six-bit flag vector;
- a six-bit flag write mask that names the flags this operation is allowed to update.

A result-write strobe tells the register file whether to store the result. The compare operations drop the result and keep only the flags. The status register outside the block merges the flag vector under the mask.

The operations cover several groups:
- add and subtract, each with and without carry;
- compare, including a carry-chained compare;
- AND, OR and XOR;
- one's and two's complement;
- increment and decrement;
- the left and right shifts, the rotates through carry, and the arithmetic right shift;
- the nibble swap.

The block sits between operand fetch and write-back, so it has no handshake of its own. Its outputs follow its inputs within the same cycle.

Top module: `byte_alu`

## Requirements
- R1: Flag vector and mask bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. Opcodes are ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, CPC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, INC=11, DEC=12, LSL=13, LSR=14, ROL=15, ROR=16, ASR=17, SWAP=18. ADD/ADC return a+b(+carry_in), with C the carry out of bit 7. SUB/SBC return a-b(-carry_in), with C the borrow out of bit 7. All six flags are in the mask for these operations.
- R2: H is the carry out of bit 3 for additions and the borrow into bit 4 for subtractions, compares and negate.
- R3: V is signed overflow of the arithmetic operation. S equals N xor V whenever S is in the mask. N is result bit 7.
- R4: AND, OR and XOR update only Z, N, V and S, and V is 0.
- R5: COM returns 0xFF minus a, sets C to 1 and V to 0, and updates Z, C, N, V and S.
- R6: NEG returns 0x00 minus a, updates all six flags, and sets C exactly when a is nonzero and V exactly when a is 0x80.
- R7: INC and DEC return a+1 and a-1 and update only Z, N, V and S. V is set for INC of 0x7F and for DEC of 0x80.
- R8: For SBC and CPC, Z is 1 only when the result is zero and zero_in is 1.
- R9: CMP and CPC produce the same flags as SUB and SBC on the same inputs, and hold result_we low. Every other defined opcode raises result_we.
- R10: LSL shifts in 0 and ROL shifts in carry_in at bit 0. Both move bit 7 to C and bit 3 to H, and set V to N xor C. All six flags are in the mask.
- R11: LSR shifts in 0, ROR shifts in carry_in and ASR keeps bit 7. All three move bit 0 to C, set V to N xor C, and leave H out of the mask.
- R12: SWAP exchanges the two nibbles and has an all-zero flag mask.
- R13: Flag vector bits outside the mask are 0. Opcodes 19 to 31 give result 0, an all-zero mask and result_we low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 5 | Operation select (encoding in R1) |
| opnd_a | input | 8 | First operand, destination register value |
| opnd_b | input | 8 | Second operand, register or immediate |
| carry_in | input | 1 | Current C flag |
| zero_in | input | 1 | Current Z flag, used by the chained subtract and compare |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result should be written back |
| flags_out | output | 6 | New flag values, zero where not masked |
| flags_we | output | 6 | Flags this operation updates |

## Verification
The embedded checks are immediate assertions on combinational values. They assume that op_code, both operands and both flag inputs are two-state and settled when they are evaluated. The bench keeps to this by changing all inputs together on the falling clock edge and reading outputs one nanosecond later.

The random stimulus draws opcodes from 0 to 20, so two reserved codes are mixed in with the nineteen defined ones. Operands are full-range bytes, and both flag inputs take both values, so every carry, borrow and sticky-zero path is reachable.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;
  localparam int OP_W   = 5;
  localparam int FLAG_N = 6;

  // flag vector bit positions
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CPC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_LSL  = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROL  = 5'd15,
    OP_ROR  = 5'd16,
    OP_ASR  = 5'd17,
    OP_SWAP = 5'd18
  } alu_op_e;

  localparam logic [FLAG_N-1:0] MASK_ALL   = 6'b111111;
  localparam logic [FLAG_N-1:0] MASK_ZNVS  = 6'b011110;
  localparam logic [FLAG_N-1:0] MASK_ZCNVS = 6'b011111;
endpackage

// File: rtl/byte_alu_addsub.sv
`timescale 1ns/1ps
module byte_alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              sub_i,   // 1: x - y - bin, 0: x + y + cin
  input  logic              cb_i,    // carry-in or borrow-in
  output logic [DATA_W-1:0] sum_o,
  output logic              cy_o,    // carry out (add) / borrow out (sub)
  output logic              half_o,  // carry from low half / borrow into high half
  output logic              ovf_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] y_eff;
  logic [DATA_W:0]   chain;

  assign y_eff    = sub_i ? ~y_i : y_i;
  assign chain[0] = sub_i ? ~cb_i : cb_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rip
    assign sum_o[i]   = x_i[i] ^ y_eff[i] ^ chain[i];
    assign chain[i+1] = (x_i[i] & y_eff[i]) | ((x_i[i] ^ y_eff[i]) & chain[i]);
  end

  assign cy_o   = sub_i ? ~chain[DATA_W] : chain[DATA_W];
  assign half_o = sub_i ? ~chain[HALF]   : chain[HALF];
  assign ovf_o  = chain[DATA_W-1] ^ chain[DATA_W];

  always_comb begin
    // R1
    sum_match_chk: assert ({chain[DATA_W], sum_o} ==
                           ({1'b0, x_i} + {1'b0, y_eff} + {{DATA_W{1'b0}}, chain[0]}));
  end
endmodule

// File: rtl/byte_alu_logic.sv
`timescale 1ns/1ps
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  res_o = ~a_i;
      default: res_o = '0;
    endcase
    // R4
    and_subset_chk: assert (op_i != OP_AND || (res_o & ~a_i) == '0);
    // R5
    com_fill_chk: assert (op_i != OP_COM || (res_o ^ a_i) == {DATA_W{1'b1}});
  end
endmodule

// File: rtl/byte_alu_shift.sv
`timescale 1ns/1ps
module byte_alu_shift
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              half_o
);
  localparam int HALF = DATA_W / 2;

  logic fill_lo, fill_hi;

  always_comb begin
    fill_lo = (op_i == OP_ROL) ? cin_i : 1'b0;
    case (op_i)
      OP_ROR:  fill_hi = cin_i;
      OP_ASR:  fill_hi = a_i[DATA_W-1];
      default: fill_hi = 1'b0;
    endcase
    res_o  = '0;
    cout_o = 1'b0;
    half_o = 1'b0;
    case (op_i)
      OP_LSL, OP_ROL: begin
        res_o  = {a_i[DATA_W-2:0], fill_lo};
        cout_o = a_i[DATA_W-1];
        half_o = a_i[HALF-1];
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        res_o  = {fill_hi, a_i[DATA_W-1:1]};
        cout_o = a_i[0];
      end
      OP_SWAP: res_o = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
      default: ;
    endcase
    // R10
    rot_ones_chk: assert (!(op_i == OP_ROL || op_i == OP_ROR) ||
                          $countones({res_o, cout_o}) == $countones({a_i, cin_i}));
    // R12
    swap_ones_chk: assert (op_i != OP_SWAP || $countones(res_o) == $countones(a_i));
  end
endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic              zero_in,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [FLAG_N-1:0] flags_out,
  output logic [FLAG_N-1:0] flags_we
);
  alu_op_e op_e;
  assign op_e = alu_op_e'(op_code);

  // adder/subtractor operand steering
  logic [DATA_W-1:0] as_x, as_y, as_sum;
  logic              as_sub, as_cb, as_cy, as_half, as_ovf;

  always_comb begin
    as_x   = opnd_a;
    as_y   = opnd_b;
    as_sub = 1'b0;
    as_cb  = 1'b0;
    case (op_e)
      OP_ADC:         as_cb = carry_in;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cb = carry_in; end
      OP_NEG:         begin as_x = '0; as_y = opnd_a; as_sub = 1'b1; end
      OP_INC:         as_y = DATA_W'(1);
      OP_DEC:         begin as_y = DATA_W'(1); as_sub = 1'b1; end
      default: ;
    endcase
  end

  byte_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .x_i   (as_x),
    .y_i   (as_y),
    .sub_i (as_sub),
    .cb_i  (as_cb),
    .sum_o (as_sum),
    .cy_o  (as_cy),
    .half_o(as_half),
    .ovf_o (as_ovf)
  );

  logic [DATA_W-1:0] lg_res;
  byte_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i (op_e),
    .a_i  (opnd_a),
    .b_i  (opnd_b),
    .res_o(lg_res)
  );

  logic [DATA_W-1:0] sh_res;
  logic              sh_c, sh_h;
  byte_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .op_i  (op_e),
    .a_i   (opnd_a),
    .cin_i (carry_in),
    .res_o (sh_res),
    .cout_o(sh_c),
    .half_o(sh_h)
  );

  logic              f_c, f_z, f_n, f_v, f_s, f_h;
  logic              chain_z;
  logic [FLAG_N-1:0] mask;
  logic [DATA_W-1:0] res;
  logic              we;

  always_comb begin
    res     = '0;
    we      = 1'b0;
    mask    = '0;
    f_c     = 1'b0;
    f_h     = 1'b0;
    f_v     = 1'b0;
    chain_z = (op_e == OP_SBC) || (op_e == OP_CPC);
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        res = as_sum; f_c = as_cy; f_h = as_half; f_v = as_ovf;
        mask = MASK_ALL; we = 1'b1;
      end
      OP_CMP, OP_CPC: begin
        res = as_sum; f_c = as_cy; f_h = as_half; f_v = as_ovf;
        mask = MASK_ALL;
      end
      OP_INC, OP_DEC: begin
        res = as_sum; f_v = as_ovf; mask = MASK_ZNVS; we = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res = lg_res; mask = MASK_ZNVS; we = 1'b1;
      end
      OP_COM: begin
        res = lg_res; f_c = 1'b1; mask = MASK_ZCNVS; we = 1'b1;
      end
      OP_LSL, OP_ROL: begin
        res = sh_res; f_c = sh_c; f_h = sh_h;
        f_v = sh_res[DATA_W-1] ^ sh_c;
        mask = MASK_ALL; we = 1'b1;
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        res = sh_res; f_c = sh_c;
        f_v = sh_res[DATA_W-1] ^ sh_c;
        mask = MASK_ZCNVS; we = 1'b1;
      end
      OP_SWAP: begin
        res = sh_res; we = 1'b1;
      end
      default: ;
    endcase
    f_n = res[DATA_W-1];
    f_z = (res == '0) && (!chain_z || zero_in);
    f_s = f_n ^ f_v;

    result    = (op_e == OP_CMP || op_e == OP_CPC) ? '0 : res;
    result_we = we;
    flags_we  = mask;
    flags_out = {f_h, f_s, f_v, f_n, f_z, f_c} & mask;

    // R13
    unmasked_zero_chk: assert ((flags_out & ~flags_we) == '0);
    // R8
    sticky_z_chk: assert (!((op_e == OP_SBC || op_e == OP_CPC) && !zero_in) ||
                          !flags_out[FL_Z]);
    // R9
    cmp_nowrite_chk: assert (!(op_e == OP_CMP || op_e == OP_CPC) || !result_we);
    // R12
    swap_noflag_chk: assert (op_e != OP_SWAP || flags_we == '0);
    // R13
    reserved_quiet_chk: assert (op_code <= 5'd18 ||
                                (flags_we == '0 && !result_we && result == '0));
  end
endmodule

// File: tb/byte_alu_tb.sv
`timescale 1ns/1ps
module byte_alu_tb_top;
  import byte_alu_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       carry_in = 1'b0, zero_in = 1'b0;
  logic [7:0] result;
  logic       result_we;
  logic [5:0] flags_out, flags_we;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  byte_alu dut_i (
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .carry_in (carry_in),
    .zero_in  (zero_in),
    .result   (result),
    .result_we(result_we),
    .flags_out(flags_out),
    .flags_we (flags_we)
  );

  typedef struct packed {
    logic [7:0] res;
    logic       we;
    logic [5:0] fl;
    logic [5:0] msk;
  } exp_t;

  function automatic exp_t model(input logic [4:0] o, input logic [7:0] a, b,
                                 input logic ci, zi);
    exp_t e;
    logic [8:0] t;
    logic c, z, n, v, h, cv;
    e = '0; c = 0; v = 0; h = 0; z = 0; n = 0;
    cv = (o == 5'd1 || o == 5'd3 || o == 5'd5) ? ci : 1'b0;
    case (o)
      5'd0, 5'd1: begin
        t = {1'b0, a} + {1'b0, b} + {8'b0, cv};
        e.res = t[7:0]; c = t[8];
        h = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cv}) > 5'd15;
        v = (a[7] == b[7]) && (t[7] != a[7]);
        e.msk = 6'h3F; e.we = 1;
      end
      5'd2, 5'd3, 5'd4, 5'd5: begin
        t = {1'b0, a} - {1'b0, b} - {8'b0, cv};
        e.res = t[7:0]; c = t[8];
        h = {1'b0, a[3:0]} < ({1'b0, b[3:0]} + {4'b0, cv});
        v = (a[7] != b[7]) && (t[7] != a[7]);
        e.msk = 6'h3F; e.we = (o == 5'd2 || o == 5'd3);
      end
      5'd6, 5'd7, 5'd8: begin
        e.res = (o == 5'd6) ? (a & b) : (o == 5'd7) ? (a | b) : (a ^ b);
        e.msk = 6'h1E; e.we = 1;
      end
      5'd9:  begin e.res = 8'hFF - a; c = 1; e.msk = 6'h1F; e.we = 1; end
      5'd10: begin
        e.res = 8'h00 - a; c = (a != 0); h = (a[3:0] != 0); v = (a == 8'h80);
        e.msk = 6'h3F; e.we = 1;
      end
      5'd11: begin e.res = a + 8'd1; v = (a == 8'h7F); e.msk = 6'h1E; e.we = 1; end
      5'd12: begin e.res = a - 8'd1; v = (a == 8'h80); e.msk = 6'h1E; e.we = 1; end
      5'd13, 5'd15: begin
        e.res = {a[6:0], (o == 5'd15) ? ci : 1'b0};
        c = a[7]; h = a[3]; v = e.res[7] ^ c; e.msk = 6'h3F; e.we = 1;
      end
      5'd14, 5'd16, 5'd17: begin
        e.res = {(o == 5'd16) ? ci : (o == 5'd17) ? a[7] : 1'b0, a[7:1]};
        c = a[0]; v = e.res[7] ^ c; e.msk = 6'h1F; e.we = 1;
      end
      5'd18: begin e.res = {a[3:0], a[7:4]}; e.we = 1; end
      default: ;
    endcase
    n = e.res[7];
    z = (e.res == 0) && (!(o == 5'd3 || o == 5'd5) || zi);
    e.fl = {h, n ^ v, v, n, z, c} & e.msk;
    if (o == 5'd4 || o == 5'd5) e.res = '0;
    return e;
  endfunction

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'd0, 5'd1, 5'd2: return "R1";
      5'd3: return "R8";
      5'd4, 5'd5: return "R9";
      5'd6, 5'd7, 5'd8: return "R4";
      5'd9: return "R5";
      5'd10: return "R6";
      5'd11, 5'd12: return "R7";
      5'd13, 5'd15: return "R10";
      5'd14, 5'd16, 5'd17: return "R11";
      5'd18: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check_out(input string tag, input exp_t e);
    n_checks++;
    if (result !== e.res || result_we !== e.we || flags_out !== e.fl || flags_we !== e.msk) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%02h b=%02h ci=%0b zi=%0b: got res=%02h we=%0b fl=%06b msk=%06b, exp res=%02h we=%0b fl=%06b msk=%06b",
               tag, op_code, opnd_a, opnd_b, carry_in, zero_in,
               result, result_we, flags_out, flags_we, e.res, e.we, e.fl, e.msk);
    end
  endtask

  task automatic run_vec(input logic [4:0] o, input logic [7:0] a, b,
                         input logic ci, zi, input string tag);
    @(negedge clk);
    op_code = o; opnd_a = a; opnd_b = b; carry_in = ci; zero_in = zi;
    #1;
    check_out(tag, model(o, a, b, ci, zi));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state: ADD of zeros gives zero result with Z set
    check_out("R1", model(5'd0, 8'h00, 8'h00, 1'b0, 1'b0));
    rst_n = 1'b1;

    run_vec(OP_ADD, 8'h0F, 8'h01, 0, 0, "R2");   // half carry
    run_vec(OP_ADD, 8'h7F, 8'h01, 0, 0, "R3");   // signed overflow
    run_vec(OP_ADC, 8'hFF, 8'h00, 1, 0, "R1");   // carry out, zero
    run_vec(OP_SUB, 8'h00, 8'h01, 0, 0, "R1");   // borrow
    run_vec(OP_SUB, 8'h80, 8'h01, 0, 0, "R3");   // overflow on subtract
    run_vec(OP_SBC, 8'h10, 8'h0F, 1, 0, "R8");   // zero result, Z stays clear
    run_vec(OP_SBC, 8'h10, 8'h0F, 1, 1, "R8");   // zero result, Z kept set
    run_vec(OP_CPC, 8'h05, 8'h05, 0, 1, "R9");
    run_vec(OP_CMP, 8'h03, 8'h09, 0, 0, "R9");
    run_vec(OP_AND, 8'hF0, 8'h3C, 1, 0, "R4");
    run_vec(OP_XOR, 8'h5A, 8'h5A, 0, 0, "R4");
    run_vec(OP_COM, 8'h55, 8'h00, 0, 0, "R5");
    run_vec(OP_NEG, 8'h80, 8'h00, 0, 0, "R6");
    run_vec(OP_NEG, 8'h00, 8'h00, 1, 0, "R6");
    run_vec(OP_INC, 8'h7F, 8'h00, 1, 0, "R7");
    run_vec(OP_DEC, 8'h80, 8'h00, 0, 0, "R7");
    run_vec(OP_LSL, 8'h88, 8'h00, 0, 0, "R10");
    run_vec(OP_ROL, 8'h40, 8'h00, 1, 0, "R10");
    run_vec(OP_LSR, 8'h01, 8'h00, 1, 0, "R11");
    run_vec(OP_ROR, 8'h02, 8'h00, 1, 0, "R11");
    run_vec(OP_ASR, 8'h81, 8'h00, 0, 0, "R11");
    run_vec(OP_SWAP, 8'hA5, 8'h00, 1, 1, "R12");
    run_vec(5'd25, 8'hFF, 8'hFF, 1, 1, "R13");

    for (int i = 0; i < 4000; i++) begin
      logic [4:0] o;
      o = 5'($urandom_range(0, 20));
      run_vec(o, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), tag_of(o));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule